// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register

This block gathers interrupt requests from a small group of peripherals into one 8-bit flag word on a simple register bus. Four of the sources are single-cycle event pulses: A/D conversion done, serial-port transfer complete, timer period match and timer overflow. Each pulse is caught in a sticky flag that only software clears. Two further flags show the live state of a serial receive buffer (full) and a serial transmit buffer (empty). They cannot be written, and they change only when the peripheral's own buffer state changes.

A second register at another address holds an enable mask. The interrupt request output is high when any implemented flag is set with its enable bit, and the global enable input is high. Flags latch whether or not they are enabled. Software must therefore clear stale flags before it enables a source, and clear each flag again after servicing it. The bus has a single-cycle write strobe and a combinational read path.

Top module: `periph_irq_flags`

## Requirements
- R1: After reset, the flag register (address 0) and the enable register (address 1) both read 0x00, and `irq` is 0.
- R2: Flag bits 7 and 2 always read 0. Writes to those positions leave them at 0.
- R3: A pulse on `ev_adc_done`, `ev_ssp_done`, `ev_tmr_match` or `ev_tmr_ovf` sets flag bit 6, 3, 1 or 0 respectively, visible one cycle later. With no event and no flag write, the bit holds its value.
- R4: A write to address 0 loads bits 6, 3, 1 and 0 from the write data. A 0 clears the bit and a 1 sets it.
- R5: When an event and a write of 0 reach the same sticky bit in the same cycle, the bit ends up set.
- R6: Flag bit 5 reads the value `rx_buf_full` had one cycle earlier. Bus writes to bit 5 have no effect.
- R7: Flag bit 4 reads the value `tx_buf_empty` had one cycle earlier. Bus writes to bit 4 have no effect.
- R8: Flags set on their events even when the matching enable bit and `global_en` are both 0.
- R9: A write to address 1 stores all 8 data bits in the enable register, and a read of address 1 returns them.
- R10: `irq` equals `global_en` AND the OR over bits 6, 5, 4, 3, 1 and 0 of (flag AND enable). Enable bits 7 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register select: 0 selects the flags, 1 selects the enables |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the register at `bus_addr` |
| ev_adc_done | input | 1 | A/D conversion done pulse |
| ev_ssp_done | input | 1 | Serial-port transfer complete pulse |
| ev_tmr_match | input | 1 | Timer period-match pulse |
| ev_tmr_ovf | input | 1 | Timer overflow pulse |
| rx_buf_full | input | 1 | Receive buffer holds data |
| tx_buf_empty | input | 1 | Transmit buffer is empty |
| global_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check the per-cycle rules on every cycle:
- the unused bits stay zero;
- an event sets its flag even against a clearing write;
- a sticky bit holds when nothing touches it, and clears on a write of 0;
- both mirrors track their buffer input one cycle later;
- `irq` stays low without `global_en` and never rises without an enabled flag.

Two things come only from the bench's sweeps. The first is that the full write-data space combined with event and buffer patterns yields the exact flag word. The second is that every enable mask reads back unchanged and gives the correct `irq` for both global-enable values.

// File: rtl/pif_pkg.sv
// Package: flag layout shared by the flag register, its cells and its checker.
// Assumes an 8-bit register where the bit positions are decoded by software.
package pif_pkg;
    localparam int REG_W      = 8;
    localparam int N_STICKY   = 4;
    localparam int N_MIRROR   = 2;
    localparam int N_UNUSED   = 2;
    localparam int FLAG_ADDR  = 0;
    localparam int EN_ADDR    = 1;

    // Positions of the sticky flags: A/D done, serial done, period match, overflow.
    localparam int STICKY_POS [N_STICKY] = '{6, 3, 1, 0};
    // Positions of the mirrors: receive full, transmit empty.
    localparam int MIRROR_POS [N_MIRROR] = '{5, 4};
    // Positions that are not implemented.
    localparam int UNUSED_POS [N_UNUSED] = '{7, 2};

    // Mask of the bits that take part in the interrupt request.
    localparam logic [REG_W-1:0] IMPL_MASK = 8'b0111_1011;
endpackage

// File: rtl/pif_sticky_bit.sv
// Module: one sticky interrupt flag.
// A hardware event sets the bit. A software write loads it from the bus data.
// Assumes the event is a single-cycle pulse. The event has priority over the write.
module pif_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic wr_en,
    input  logic wr_bit,
    output logic q
);
    // Latch the event, else take the software value, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set_ev)
            q <= 1'b1;
        else if (wr_en)
            q <= wr_bit;
    end
endmodule

// File: rtl/pif_mirror_bit.sv
// Module: a read-only flag that follows a peripheral status level.
// Assumes the status input is synchronous to clk. One register stage is added.
module pif_mirror_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic q
);
    // Sample the peripheral level every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else
            q <= src;
    end
endmodule

// File: rtl/pif_irq_combine.sv
// Module: masked OR of the flags into a single request, gated by a global enable.
// Assumes that IMPL_MASK excludes the unused bit positions.
module pif_irq_combine #(
    parameter int               W         = 8,
    parameter logic [W-1:0]     IMPL_MASK = '1
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] enables,
    input  logic         global_en,
    output logic         irq
);
    // Combine the enabled flags into the request.
    always_comb begin
        irq = global_en & (|(flags & enables & IMPL_MASK));
    end
endmodule

// File: rtl/periph_irq_flags.sv
// Module: peripheral interrupt flag register with enable mask and combined request.
// Address FLAG_ADDR holds the flags and address EN_ADDR holds the enables.
// Assumes a single-cycle write strobe and a combinational read path.
// Reset is synchronous and active low.
module periph_irq_flags
    import pif_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ev_adc_done,
    input  logic              ev_ssp_done,
    input  logic              ev_tmr_match,
    input  logic              ev_tmr_ovf,
    input  logic              rx_buf_full,
    input  logic              tx_buf_empty,
    input  logic              global_en,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);

    logic                 wr_flag;
    logic                 wr_en_reg;
    logic [N_STICKY-1:0]  ev_vec;
    logic [N_MIRROR-1:0]  st_vec;
    logic [REG_W-1:0]     flag_q;
    logic [REG_W-1:0]     en_q;

    // Decode the write strobe per register.
    always_comb begin
        wr_flag   = bus_wr && (bus_addr == A_FLAG);
        wr_en_reg = bus_wr && (bus_addr == A_EN);
    end

    // Order the event and status inputs to match the package position tables.
    always_comb begin
        ev_vec = {ev_tmr_ovf, ev_tmr_match, ev_ssp_done, ev_adc_done};
        st_vec = {tx_buf_empty, rx_buf_full};
    end

    // One sticky cell per event flag.
    for (genvar k = 0; k < N_STICKY; k++) begin : g_sticky
        pif_sticky_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (ev_vec[k]),
            .wr_en  (wr_flag),
            .wr_bit (bus_wdata[STICKY_POS[k]]),
            .q      (flag_q[STICKY_POS[k]])
        );
    end

    // One mirror cell per buffer-state flag. Bus writes never reach these cells.
    for (genvar m = 0; m < N_MIRROR; m++) begin : g_mirror
        pif_mirror_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (st_vec[m]),
            .q     (flag_q[MIRROR_POS[m]])
        );
    end

    // Tie the unimplemented positions to 0.
    for (genvar u = 0; u < N_UNUSED; u++) begin : g_unused
        assign flag_q[UNUSED_POS[u]] = 1'b0;
    end

    // Enable mask register, all bits writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en_reg)
            en_q <= bus_wdata;
    end

    // Read mux.
    always_comb begin
        if (bus_addr == A_EN)
            bus_rdata = en_q;
        else if (bus_addr == A_FLAG)
            bus_rdata = flag_q;
        else
            bus_rdata = '0;
    end

    pif_irq_combine #(
        .W         (REG_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_irq (
        .flags     (flag_q),
        .enables   (en_q),
        .global_en (global_en),
        .irq       (irq)
    );
endmodule

// File: rtl/pif_checker.sv
// Module: property checker for periph_irq_flags, attached through bind.
// Assumes the flag and enable state are connected from inside the top module.
module pif_checker
    import pif_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              ev_adc_done,
    input logic              rx_buf_full,
    input logic              tx_buf_empty,
    input logic              global_en,
    input logic              irq,
    input logic [REG_W-1:0]  flag_q,
    input logic [REG_W-1:0]  en_q
);
    logic wr_f;
    assign wr_f = bus_wr && (bus_addr == ADDR_W'(FLAG_ADDR));

    // R2: the unimplemented positions never hold a 1.
    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[7] == 1'b0) && (flag_q[2] == 1'b0));

    // R3, R5: an event sets its flag, even when a write of 0 arrives with it.
    assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_adc_done |=> flag_q[6]);

    // R3: with no event and no flag write, the bit holds.
    assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_adc_done && !wr_f) |=> $stable(flag_q[6]));

    // R4: a write of 0 with no event clears the bit.
    assert_write_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_f && !bus_wdata[6] && !ev_adc_done) |=> !flag_q[6]);

    // R6: the receive flag tracks the buffer level one cycle later.
    assert_rx_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_q[5] == $past(rx_buf_full)));

    // R7: the transmit flag tracks the buffer level one cycle later.
    assert_tx_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_q[4] == $past(tx_buf_empty)));

    // R10: without the global enable there is no request.
    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |-> !irq);

    // R10: a request needs at least one enabled, implemented flag.
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag_q & en_q & IMPL_MASK) != '0));
endmodule

bind periph_irq_flags pif_checker #(.ADDR_W(ADDR_W)) u_pif_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .ev_adc_done (ev_adc_done),
    .rx_buf_full (rx_buf_full),
    .tx_buf_empty(tx_buf_empty),
    .global_en   (global_en),
    .irq         (irq),
    .flag_q      (flag_q),
    .en_q        (en_q)
);

// File: tb/tb_periph_irq_flags.sv
// Bench: sweeps the flag register against all write values and all enable masks.
// The bench computes every expected value itself.
module tb_periph_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ev_adc_done = 1'b0, ev_ssp_done = 1'b0, ev_tmr_match = 1'b0, ev_tmr_ovf = 1'b0;
    logic       rx_buf_full = 1'b0, tx_buf_empty = 1'b0, global_en = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    periph_irq_flags #(.ADDR_W(1)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_adc_done(ev_adc_done), .ev_ssp_done(ev_ssp_done),
        .ev_tmr_match(ev_tmr_match), .ev_tmr_ovf(ev_tmr_ovf),
        .rx_buf_full(rx_buf_full), .tx_buf_empty(tx_buf_empty),
        .global_en(global_en), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ev(input logic [3:0] e);
        {ev_adc_done, ev_ssp_done, ev_tmr_match, ev_tmr_ovf} = e;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] exp_f;
        logic [3:0] e;
        logic       exp_irq;
        repeat (3) step();
        // R1: reset state
        bus_addr = 1'b0; #1; chk("R1 flags", bus_rdata, 8'h00);
        bus_addr = 1'b1; #1; chk("R1 enables", bus_rdata, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        step();

        // R2 R3 R4 R5 R6 R7: every write value with an event and buffer pattern
        for (int i = 0; i < 256; i++) begin
            e = 4'((i * 7) >> 2);
            bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = 8'(i);
            set_ev(e);
            rx_buf_full = bus_wdata[5] ^ bus_wdata[0];
            tx_buf_empty = bus_wdata[4] ^ bus_wdata[1];
            exp_f = '0;
            exp_f[6] = e[3] | bus_wdata[6];
            exp_f[3] = e[2] | bus_wdata[3];
            exp_f[1] = e[1] | bus_wdata[1];
            exp_f[0] = e[0] | bus_wdata[0];
            exp_f[5] = rx_buf_full;
            exp_f[4] = tx_buf_empty;
            step();
            bus_wr = 1'b0; set_ev(4'b0);
            chk("R2 R4 R5 R6 R7 write", bus_rdata, exp_f);
            step();
            chk("R3 hold", bus_rdata, exp_f);
        end

        // R8: flags set while enables and global enable are 0
        rx_buf_full = 1'b0; tx_buf_empty = 1'b0; global_en = 1'b0;
        bus_wr = 1'b1; bus_wdata = 8'h00; step(); bus_wr = 1'b0;
        chk("R4 clear", bus_rdata, 8'h00);
        set_ev(4'hF); step(); set_ev(4'h0);
        chk("R8 set while masked", bus_rdata, 8'h4B);
        chk("R8 irq masked", {7'd0, irq}, 8'h00);

        // R9 R10: every enable mask with both global enable values
        for (int m = 0; m < 256; m++) begin
            bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'(m);
            rx_buf_full = bus_wdata[0]; tx_buf_empty = bus_wdata[7];
            global_en = 1'b0;
            step();
            bus_wr = 1'b0;
            chk("R9 enable readback", bus_rdata, 8'(m));
            exp_f = 8'h4B | {2'b0, rx_buf_full, tx_buf_empty, 4'b0};
            chk("R10 irq global off", {7'd0, irq}, 8'h00);
            global_en = 1'b1; #1;
            exp_irq = |(exp_f & 8'(m) & 8'h7B);
            chk("R10 irq global on", {7'd0, irq}, {7'd0, exp_irq});
        end
        finish_run();
    end
endmodule